// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a bus-programmable watchdog built around a down-counter. While the counter is running, it counts down once per clock. When it first reaches zero it raises a pending interrupt and restarts from the programmed load value. If it reaches zero a second time while that interrupt is still unacknowledged, and the reset stage is armed, it asserts a system reset. Software keeps the system alive by acknowledging the interrupt, which also restarts the count.

Software reaches the block through an APB-style register port. The port gives access to the reload value, the live count, a two-bit control word, an acknowledge register, raw and masked interrupt status, a write-lock register and four read-only identification bytes. A write-lock guards every register except itself. Writing the key opens the other registers to writes, and writing any other value closes them again.

Top module: `twostage_watchdog`

## Requirements
- R1: After a synchronous reset the count (0x004) and load (0x000) registers read 0xFFFFFFFF. Control (0x008) reads 0, the lock register (0xC00) reads 0 (unlocked), raw status (0x010) reads 0, and both `irq` and `sys_rst_o` are low.
- R2: A write to 0x000 stores the value and loads it into the counter at the same clock edge. A written value of 0 is stored as 1.
- R3: While control bit 0 is 1, the counter drops by one on every clock edge. While control bit 0 is 0, the counter holds its value.
- R4: When the running counter is at zero and no interrupt is pending, the next edge sets raw status bit 0 and reloads the counter from the load value. From a counter value of L, the first interrupt therefore appears L+1 edges later.
- R5: When the running counter is at zero, the interrupt is still pending and control bit 1 is 1, `sys_rst_o` rises. It then stays high until the block is reset, so from count C with no interrupt pending it rises C+L+2 edges later. With control bit 1 at 0, no reset is produced.
- R6: Any write to the acknowledge register 0x00C clears raw status and reloads the counter from the load value. It takes priority over a simultaneous expiry, so repeated acknowledges keep `sys_rst_o` low.
- R7: Masked status (0x014) bit 0 and the `irq` pin equal raw status bit 0 ANDed with control bit 0.
- R8: Writing 0x1ACCE551 to 0xC00 unlocks the block, and writing any other value locks it. Reading 0xC00 returns 1 when locked and 0 when unlocked.
- R9: While the block is locked, writes to the load, control and acknowledge registers change nothing.
- R10: The identification registers at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x05, 0x18, 0x14 and 0x00 in bits 7:0, forming 0x141805 in the low 24 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq | output | 1 | Masked first-stage interrupt |
| sys_rst_o | output | 1 | Sticky second-stage system reset request |

## Verification
A corrupted counter shows up as an interrupt or reset edge on the wrong cycle. The bench therefore times `irq` and `sys_rst_o` to the exact edge counted from a known load value, and a skew of a single cycle is caught. A lost or stuck pending flag shows up as a reset that comes too early, never comes, or comes in the unarmed mode. A wrong lock state shows up on the next readback of a register whose write should have been blocked or accepted. All of these are visible within one timeout period of the stimulus.

// File: rtl/twd_pkg.sv
// Package: shared constants and types for the two-stage watchdog.
// Assumes a 12-bit byte address and 32-bit data on the register port.
package twd_pkg;
    localparam int unsigned     BUS_W      = 32;
    localparam int unsigned     ADDR_W     = 12;
    localparam int unsigned     ID_REGS    = 4;
    localparam logic [31:0]     UNLOCK_KEY = 32'h1ACC_E551;
    localparam logic [23:0]     PART_ID    = 24'h14_1805;

    localparam logic [11:0] OFF_LOAD   = 12'h000;
    localparam logic [11:0] OFF_COUNT  = 12'h004;
    localparam logic [11:0] OFF_CTRL   = 12'h008;
    localparam logic [11:0] OFF_ACK    = 12'h00C;
    localparam logic [11:0] OFF_RAW    = 12'h010;
    localparam logic [11:0] OFF_MASKED = 12'h014;
    localparam logic [11:0] OFF_LOCK   = 12'hC00;
    localparam logic [7:0]  OFF_ID_HI  = 8'hFE;   // ID block at 0xFE0..0xFEC

    // Control word: bit 0 runs the counter, bit 1 arms the reset stage
    typedef struct packed {
        logic rst_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/twd_lock.sv
// Module: write-lock state. A write to the lock register with the key
// opens the block, any other value closes it. Comes out of reset unlocked.
module twd_lock #(
    parameter logic [31:0] KEY = twd_pkg::UNLOCK_KEY
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_wr,
    input  logic [31:0] wdata,
    output logic        locked
);
    // Track lock state from writes to the lock register
    always_ff @(posedge clk) begin
        if (!rst_n)       locked <= 1'b0;
        else if (lock_wr) locked <= (wdata != KEY);
    end
endmodule

// File: rtl/twd_regs.sv
// Module: register decode, load and control storage, and read mux.
// Assumes single-cycle APB-style access (write on psel&penable&pwrite).
// Writes other than to the lock register are dropped while locked.
module twd_regs #(
    parameter int unsigned CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [twd_pkg::ADDR_W-1:0]    paddr,
    input  logic [twd_pkg::BUS_W-1:0]     pwdata,
    input  logic                          locked,
    input  logic [CNT_W-1:0]              count,
    input  logic                          raw,
    output logic [twd_pkg::BUS_W-1:0]     prdata,
    output twd_pkg::ctrl_t                ctrl,
    output logic                          lock_wr,
    output logic                          reload_req,
    output logic                          ack_req,
    output logic [CNT_W-1:0]              reload_val
);
    import twd_pkg::*;

    localparam logic [31:0] ID_WORD = {8'h00, PART_ID};

    logic             wr_stb, open_wr, load_wr, ctrl_wr;
    logic [CNT_W-1:0] load_q, load_in;
    logic [7:0]       id_byte [ID_REGS];

    // Decode write strobes
    assign wr_stb  = psel && penable && pwrite;
    assign open_wr = wr_stb && !locked;
    assign lock_wr = wr_stb && (paddr == OFF_LOCK);
    assign load_wr = open_wr && (paddr == OFF_LOAD);
    assign ctrl_wr = open_wr && (paddr == OFF_CTRL);
    assign ack_req = open_wr && (paddr == OFF_ACK);

    // Clamp a written load of zero to the minimum of one
    assign load_in    = (pwdata[CNT_W-1:0] == '0) ? CNT_W'(1) : pwdata[CNT_W-1:0];
    assign reload_req = load_wr || ack_req;
    assign reload_val = load_wr ? load_in : load_q;

    // Hold the load value
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '1;
        else if (load_wr) load_q <= load_in;
    end

    // Hold the control word
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (ctrl_wr) ctrl <= ctrl_t'(pwdata[1:0]);
    end

    // Split the identification word into readable bytes
    for (genvar g = 0; g < ID_REGS; g++) begin : g_id
        assign id_byte[g] = ID_WORD[8*g +: 8];
    end

    // Select read data by address
    always_comb begin
        prdata = '0;
        case (paddr)
            OFF_LOAD:   prdata = BUS_W'(load_q);
            OFF_COUNT:  prdata = BUS_W'(count);
            OFF_CTRL:   prdata = BUS_W'(ctrl);
            OFF_RAW:    prdata = BUS_W'(raw);
            OFF_MASKED: prdata = BUS_W'(raw && ctrl.run);
            OFF_LOCK:   prdata = BUS_W'(locked);
            default: begin
                if (paddr[11:4] == OFF_ID_HI)
                    prdata = BUS_W'(id_byte[paddr[3:2]]);
            end
        endcase
    end
endmodule

// File: rtl/twd_counter.sv
// Module: down-counter with two expiry stages. First zero sets the pending
// flag and reloads; a zero with the flag still set raises a sticky reset
// when armed. A reload request from the bus wins over an expiry.
module twd_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rst_en,
    input  logic             reload_req,
    input  logic             ack_req,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             raw,
    output logic             sys_rst
);
    logic expire;

    // An expiry happens on a running zero not overridden by the bus
    assign expire = run && (count == '0) && !reload_req;

    // Count down, reload on zero or on request
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '1;
        else if (reload_req) count <= reload_val;
        else if (expire)     count <= reload_val;
        else if (run)        count <= count - 1'b1;
    end

    // Pending interrupt flag
    always_ff @(posedge clk) begin
        if (!rst_n)       raw <= 1'b0;
        else if (ack_req) raw <= 1'b0;
        else if (expire)  raw <= 1'b1;
    end

    // Sticky second-stage reset
    always_ff @(posedge clk) begin
        if (!rst_n)                        sys_rst <= 1'b0;
        else if (expire && raw && rst_en)  sys_rst <= 1'b1;
    end
endmodule

// File: rtl/twostage_watchdog.sv
// Module: top of the lockable two-stage watchdog. Joins the lock, the
// register bank and the counter. Assumes one clock and synchronous reset.
module twostage_watchdog #(
    parameter int unsigned CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        irq,
    output logic        sys_rst_o
);
    twd_pkg::ctrl_t   ctrl_w;
    logic             locked_w, lock_wr_w, reload_w, ack_w, raw_w;
    logic [CNT_W-1:0] count_w, reload_val_w;

    twd_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_wr (lock_wr_w),
        .wdata   (pwdata),
        .locked  (locked_w)
    );

    twd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .locked     (locked_w),
        .count      (count_w),
        .raw        (raw_w),
        .prdata     (prdata),
        .ctrl       (ctrl_w),
        .lock_wr    (lock_wr_w),
        .reload_req (reload_w),
        .ack_req    (ack_w),
        .reload_val (reload_val_w)
    );

    twd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_w.run),
        .rst_en     (ctrl_w.rst_en),
        .reload_req (reload_w),
        .ack_req    (ack_w),
        .reload_val (reload_val_w),
        .count      (count_w),
        .raw        (raw_w),
        .sys_rst    (sys_rst_o)
    );

    // Drive the interrupt pin from the pending flag, gated by run
    assign irq = raw_w && ctrl_w.run;
endmodule

// File: rtl/twostage_watchdog_chk.sv
// Module: property checker for the two-stage watchdog, bound to the top.
// Watches the bus, the lock and the counter state over time.
module twostage_watchdog_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [11:0]      paddr,
    input logic [31:0]      pwdata,
    input logic [CNT_W-1:0] count,
    input logic             raw,
    input twd_pkg::ctrl_t   ctrl,
    input logic             locked,
    input logic             sys_rst
);
    import twd_pkg::*;

    logic wr, reload;
    assign wr     = psel && penable && pwrite;
    assign reload = wr && !locked && (paddr == OFF_LOAD || paddr == OFF_ACK);

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && count != '0 && !reload) |=> count == $past(count) - 1'b1);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !reload) |=> $stable(count));

    p_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(count == '0 && ctrl.run));

    p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(count == '0 && raw && ctrl.run && ctrl.rst_en));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> sys_rst);

    p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !locked && paddr == OFF_ACK) |=> !raw);

    p_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == OFF_LOCK) |=> (locked == ($past(pwdata) != UNLOCK_KEY)));

    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && locked && paddr == OFF_CTRL) |=> $stable(ctrl));
endmodule

bind twostage_watchdog twostage_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .count   (count_w),
    .raw     (raw_w),
    .ctrl    (ctrl_w),
    .locked  (locked_w),
    .sys_rst (sys_rst_o)
);

// File: tb/twostage_watchdog_test.sv
`timescale 1ns/1ps
module twostage_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq, sys_rst_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    typedef struct {
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t rd_q[$];

    always #2.5 clk = ~clk;

    twostage_watchdog uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq), .sys_rst_o(sys_rst_o)
    );

    // Watchdog on the run itself
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, act=%0d exp<100000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Monitor: pop the expected read and compare during its access phase
    always begin
        @(negedge clk); #1;
        if (psel && penable && !pwrite) begin
            n_tests++;
            if (rd_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: unexpected read act=%h exp=<none>", prdata);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                if (prdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%h act=%h exp=%h", it.tag, it.addr, prdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        rd_q.push_back('{addr: a, exp: e, tag: tag});
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // Count negedges until a pin goes high, up to a limit
    task automatic wait_high(input bit use_rst, input int lim, output int k);
        k = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if ((use_rst ? sys_rst_o : irq) === 1'b1) begin k = i; break; end
        end
    endtask

    initial begin
        int k;
        do_reset();
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 sys_rst", sys_rst_o, 0);
        rd(12'h000, 32'hFFFF_FFFF, "R1 load");
        rd(12'h004, 32'hFFFF_FFFF, "R1 count");
        rd(12'h008, 0, "R1 ctrl");
        rd(12'hC00, 0, "R1 lock");
        rd(12'h010, 0, "R1 raw");
        // R10 identification bytes
        rd(12'hFE0, 32'h05, "R10 id0");
        rd(12'hFE4, 32'h18, "R10 id1");
        rd(12'hFE8, 32'h14, "R10 id2");
        rd(12'hFEC, 32'h00, "R10 id3");
        // R2 load write and clamp
        wr(12'h000, 10);
        rd(12'h000, 10, "R2 load");
        rd(12'h004, 10, "R2 count");
        wr(12'h000, 0);
        rd(12'h000, 1, "R2 clamp");
        // R3 decrement three edges, then hold
        wr(12'h000, 100);
        wr(12'h008, 1);
        wr(12'h008, 0);
        rd(12'h004, 97, "R3 decrement");
        repeat (5) @(negedge clk);
        rd(12'h004, 97, "R3 hold");
        // R4 first expiry after L+1 edges
        wr(12'h000, 5);
        wr(12'h008, 1);
        wait_high(0, 20, k);
        chk("R4 irq edge", k, 6);
        rd(12'h010, 1, "R4 raw");
        // R7 masking
        chk("R7 irq pin", irq, 1);
        wr(12'h008, 0);
        chk("R7 irq masked", irq, 0);
        rd(12'h014, 0, "R7 masked off");
        rd(12'h010, 1, "R7 raw kept");
        wr(12'h008, 1);
        rd(12'h014, 1, "R7 masked on");
        // R5 unarmed: no reset
        repeat (20) @(negedge clk);
        chk("R5 unarmed", sys_rst_o, 0);
        // R6 acknowledge
        wr(12'h00C, 32'h1234);
        chk("R6 irq cleared", irq, 0);
        rd(12'h010, 0, "R6 raw cleared");
        wr(12'h008, 3);
        for (int i = 0; i < 10; i++) wr(12'h00C, 0);
        chk("R6 keepalive", sys_rst_o, 0);
        // R5 armed: reset after C+L+2 edges from the last acknowledge
        wr(12'h00C, 0);
        wait_high(1, 40, k);
        chk("R5 reset edge", k, 12);
        repeat (10) @(negedge clk);
        chk("R5 sticky", sys_rst_o, 1);
        wr(12'h00C, 0);
        chk("R5 sticky after ack", sys_rst_o, 1);
        do_reset();
        chk("R1 reset clears", sys_rst_o, 0);
        rd(12'h004, 32'hFFFF_FFFF, "R1 count again");
        // R8 and R9 lock
        wr(12'h000, 2);
        wr(12'h008, 1);
        repeat (10) @(negedge clk);
        wr(12'hC00, 32'h1ACC_E550);
        rd(12'hC00, 1, "R8 locked");
        wr(12'h000, 77);
        rd(12'h000, 2, "R9 load blocked");
        wr(12'h008, 0);
        rd(12'h008, 1, "R9 ctrl blocked");
        wr(12'h00C, 0);
        rd(12'h010, 1, "R9 ack blocked");
        wr(12'hC00, 32'h1ACC_E551);
        rd(12'hC00, 0, "R8 unlocked");
        wr(12'h000, 77);
        rd(12'h000, 77, "R8 load accepted");
        wr(12'hC00, 32'h1);
        rd(12'hC00, 1, "R8 relocked");
        repeat (3) @(negedge clk);
        if (rd_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL scoreboard: %0d reads left act=%0d exp=0", rd_q.size(), rd_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule